// File: doc/BRIEF.md
# Segmented Memory Protection Unit

This block sits between a CPU and a nonvolatile main memory and decides, in the same cycle, whether each access may proceed. Two boundary registers with 1 KB granularity cut main memory into three consecutive segments. Each segment, and a separate information-memory window, has its own read, write and execute enables. A fourth pair of 1 KB boundaries marks an encapsulated region inside main memory. Data reads into that region are refused when they come from the debug port, or from code whose program counter lies outside the region.

A refused read returns the fixed word 0x3FFF and does not strobe the memory. A refused write is dropped. A violation pulse marks the offending cycle. Each region owns a sticky violation flag that software clears by writing a 1. An interrupt is raised while any enabled flag is set. After a lock bit is written, the configuration stays frozen until reset. Reset leaves the whole device unprotected.

Top module: `mpu_top`

## Requirements
- R1: After reset, both segment boundaries read 0x51 (top of main memory in KB units), the rights register reads 0xFFF, the lock bit, the flags and the interrupt enables read 0, irq is low, and every access kind to main memory is allowed.
- R2: Main memory runs from 0x04400 up to, but not including, 0x14400. A main address whose KB number (address bits 19:10) is below boundary 1 is in segment 1. One that is not below boundary 1 but is below boundary 2 is in segment 2. Every other main address is in segment 3. Address bits 9:0 play no part in these compares.
- R3: When boundary 2 is below boundary 1, segment 2 is empty. Every main address at or above boundary 1 falls in segment 3.
- R4: The rights register holds three bits per region (bit 0 read, bit 1 write, bit 2 execute), with segment 1 in bits 2:0, segment 2 in bits 5:3 and segment 3 in bits 8:6. Access kind 0 (data read) needs the read bit, kind 1 (write) needs the write bit, and kinds 2 and 3 (fetch) need the execute bit.
- R5: Information memory, addresses 0x01800 to 0x019FF, is checked against its own rights in bits 11:9 of the rights register.
- R6: An allowed read or fetch raises mem_re and returns mem_rdata on acc_rdata. A refused one keeps mem_re low and returns 0x3FFF.
- R7: An allowed write raises mem_we. A refused write keeps mem_we low.
- R8: acc_viol is high in the same cycle as a refused access, and only then.
- R9: A data read into the encapsulated region (KB number at least the low bound and below the high bound) that lies inside main memory is refused when acc_dbg is high or acc_pc lies outside the region. The region has no effect on writes, on fetches, or on reads whose acc_pc lies inside it with acc_dbg low.
- R10: The flags register holds one sticky bit per region (bit 0 segment 1, bit 1 segment 2, bit 2 segment 3, bit 3 information memory). A refusal sets the bit of the region being accessed. Writing 1 to a bit clears it. A set in the same cycle as a clear wins.
- R11: irq is high exactly while some flag bit is set whose interrupt-enable bit is also set.
- R12: Writing 1 to bit 0 of the control register sets the lock. While it is locked, writes to the boundary, rights, region and interrupt-enable registers are ignored, and the lock cannot be cleared. Flag clearing still works.
- R13: Accesses outside main memory and information memory are never refused.

Register addresses: 0 control, 1 boundary 1, 2 boundary 2, 3 rights, 4 encapsulated low bound, 5 encapsulated high bound, 6 flags, 7 interrupt enables. Boundaries are in KB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_addr | input | 20 | Access byte address |
| acc_pc | input | 20 | Program counter of the issuing instruction |
| acc_dbg | input | 1 | Access comes from the debug port |
| mem_rdata | input | 16 | Read data from the memory array |
| acc_rdata | output | 16 | Read data returned to the requester |
| mem_re | output | 1 | Read or fetch strobe to memory |
| mem_we | output | 1 | Write strobe to memory |
| acc_viol | output | 1 | Access refused this cycle |
| irq | output | 1 | Violation interrupt |

## Verification
On every cycle, the assertions check that a refused read returns 0x3FFF, that addresses outside the protected windows never trip a violation, that a violation is followed by a set flag, that flags stay set until they are cleared, that irq only rises over a set flag, and that a lock freezes the boundaries and rights. Some behaviour appears only through the bench's scenarios. This covers where the segment edges fall for given boundaries, the empty middle segment, and the encapsulation decisions for debug and outside code. It also covers the set-over-clear collision and the reset contents of the registers. The bench drives these with directed cases and with randomly configured maps.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_SEG1 = 3'd1,
    RG_SEG2 = 3'd2,
    RG_SEG3 = 3'd3,
    RG_INFO = 3'd4
  } region_e;

  localparam int          NFLAG        = 4;
  localparam logic [15:0] BLOCKED_WORD = 16'h3FFF;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BND1 = 3'd1;
  localparam logic [2:0] RA_BND2 = 3'd2;
  localparam logic [2:0] RA_PERM = 3'd3;
  localparam logic [2:0] RA_IPLO = 3'd4;
  localparam logic [2:0] RA_IPHI = 3'd5;
  localparam logic [2:0] RA_FLAG = 3'd6;
  localparam logic [2:0] RA_IREN = 3'd7;

  // KB number of a byte address
  function automatic logic [31:0] kb_of(logic [31:0] a);
    return a >> 10;
  endfunction

  // true when the KB number of a lies in [lo_kb, hi_kb)
  function automatic logic in_kb_window(logic [31:0] a, logic [31:0] lo_kb,
                                        logic [31:0] hi_kb);
    return (kb_of(a) >= lo_kb) && (kb_of(a) < hi_kb);
  endfunction

  function automatic region_e classify(logic [31:0] a, logic [31:0] b1_kb,
                                       logic [31:0] b2_kb,
                                       logic [31:0] main_lo, logic [31:0] main_hi,
                                       logic [31:0] info_lo, logic [31:0] info_hi);
    region_e r;
    if (a >= main_lo && a < main_hi) begin
      if (kb_of(a) < b1_kb)      r = RG_SEG1;
      else if (kb_of(a) < b2_kb) r = RG_SEG2;
      else                       r = RG_SEG3;
    end else if (a >= info_lo && a < info_hi) begin
      r = RG_INFO;
    end else begin
      r = RG_NONE;
    end
    return r;
  endfunction

  // three rights bits {x,w,r} of a region
  function automatic logic [2:0] rights_of(region_e r, logic [11:0] perm);
    case (r)
      RG_SEG1: return perm[2:0];
      RG_SEG2: return perm[5:3];
      RG_SEG3: return perm[8:6];
      RG_INFO: return perm[11:9];
      default: return 3'b111;
    endcase
  endfunction

  // kind 0 read, 1 write, 2/3 fetch
  function automatic logic kind_granted(logic [1:0] kind, logic [2:0] rwx);
    if (kind[1])      return rwx[2];
    else if (kind[0]) return rwx[1];
    else              return rwx[0];
  endfunction

endpackage

// File: rtl/mpu_regs.sv
module mpu_regs
  import mpu_pkg::*;
#(
  parameter int          KW      = 10,
  parameter logic [KW-1:0] RST_BND = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [NFLAG-1:0]  flags,
  output logic [15:0]       cfg_rdata,
  output logic [KW-1:0]     bnd1,
  output logic [KW-1:0]     bnd2,
  output logic [11:0]       perm,
  output logic [KW-1:0]     ip_lo,
  output logic [KW-1:0]     ip_hi,
  output logic [NFLAG-1:0]  irq_en,
  output logic              lock,
  output logic [NFLAG-1:0]  clr_mask
);

  logic cfg_wr_ok;
  assign cfg_wr_ok = cfg_we && !lock;
  assign clr_mask  = (cfg_we && cfg_addr == RA_FLAG) ? cfg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd1   <= RST_BND;
      bnd2   <= RST_BND;
      perm   <= 12'hFFF;
      ip_lo  <= '0;
      ip_hi  <= '0;
      irq_en <= '0;
      lock   <= 1'b0;
    end else if (cfg_wr_ok) begin
      case (cfg_addr)
        RA_CTRL: lock   <= cfg_wdata[0];
        RA_BND1: bnd1   <= cfg_wdata[KW-1:0];
        RA_BND2: bnd2   <= cfg_wdata[KW-1:0];
        RA_PERM: perm   <= cfg_wdata[11:0];
        RA_IPLO: ip_lo  <= cfg_wdata[KW-1:0];
        RA_IPHI: ip_hi  <= cfg_wdata[KW-1:0];
        RA_IREN: irq_en <= cfg_wdata[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_CTRL: cfg_rdata[0]          = lock;
      RA_BND1: cfg_rdata[KW-1:0]     = bnd1;
      RA_BND2: cfg_rdata[KW-1:0]     = bnd2;
      RA_PERM: cfg_rdata[11:0]       = perm;
      RA_IPLO: cfg_rdata[KW-1:0]     = ip_lo;
      RA_IPHI: cfg_rdata[KW-1:0]     = ip_hi;
      RA_FLAG: cfg_rdata[NFLAG-1:0]  = flags;
      RA_IREN: cfg_rdata[NFLAG-1:0]  = irq_en;
      default: cfg_rdata = '0;
    endcase
  end

  // R12: lock never drops before reset
  p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  // R12: a locked map keeps its boundaries and rights
  p_lock_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(bnd1) && $stable(bnd2) && $stable(perm)));

endmodule

// File: rtl/mpu_check.sv
module mpu_check
  import mpu_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter int          KW      = 10,
  parameter logic [31:0] MAIN_LO = 32'h04400,
  parameter logic [31:0] MAIN_HI = 32'h14400,
  parameter logic [31:0] INFO_LO = 32'h01800,
  parameter logic [31:0] INFO_HI = 32'h01A00
) (
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] acc_pc,
  input  logic              acc_dbg,
  input  logic [KW-1:0]     bnd1,
  input  logic [KW-1:0]     bnd2,
  input  logic [11:0]       perm,
  input  logic [KW-1:0]     ip_lo,
  input  logic [KW-1:0]     ip_hi,
  output region_e           region,
  output logic              rights_ok,
  output logic              ip_block,
  output logic              refused,
  output logic [NFLAG-1:0]  set_mask
);

  logic [31:0] a32, pc32;
  logic        addr_in_ip, pc_in_ip, in_main;

  assign a32  = 32'(acc_addr);
  assign pc32 = 32'(acc_pc);

  assign region     = classify(a32, 32'(bnd1), 32'(bnd2),
                               MAIN_LO, MAIN_HI, INFO_LO, INFO_HI);
  assign in_main    = (region == RG_SEG1) || (region == RG_SEG2) || (region == RG_SEG3);
  assign addr_in_ip = in_kb_window(a32, 32'(ip_lo), 32'(ip_hi));
  assign pc_in_ip   = in_kb_window(pc32, 32'(ip_lo), 32'(ip_hi));

  assign rights_ok = kind_granted(acc_kind, rights_of(region, perm));
  assign ip_block  = in_main && (acc_kind == 2'd0) && addr_in_ip &&
                     (acc_dbg || !pc_in_ip);
  assign refused   = acc_valid && (!rights_ok || ip_block);

  // one flag per region, flag i belongs to region i+1
  for (genvar i = 0; i < NFLAG; i++) begin : g_set
    assign set_mask[i] = refused && (region == region_e'(i + 1));
  end

endmodule

// File: rtl/mpu_flags.sv
module mpu_flags
  import mpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_mask,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  assign irq = |(flags & irq_en);

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    // R10: a flag holds until a 1 is written to it
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_mask[i]) |=> flags[i]);
    // R10: a set beats a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> flags[i]);
  end

  // R11: no interrupt without a pending flag
  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

endmodule

// File: rtl/mpu_top.sv
module mpu_top
  import mpu_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter logic [31:0] MAIN_LO = 32'h04400,
  parameter logic [31:0] MAIN_HI = 32'h14400,
  parameter logic [31:0] INFO_LO = 32'h01800,
  parameter logic [31:0] INFO_HI = 32'h01A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] acc_pc,
  input  logic              acc_dbg,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       acc_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              acc_viol,
  output logic              irq
);

  localparam int          KW      = ADDR_W - 10;
  localparam logic [KW-1:0] RST_BND = KW'(MAIN_HI >> 10);

  logic [KW-1:0]    bnd1, bnd2, ip_lo, ip_hi;
  logic [11:0]      perm;
  logic [NFLAG-1:0] irq_en, clr_mask, set_mask, flags;
  logic             lock, rights_ok, ip_block, refused;
  region_e          region;

  mpu_regs #(.KW(KW), .RST_BND(RST_BND)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flags(flags), .cfg_rdata(cfg_rdata),
    .bnd1(bnd1), .bnd2(bnd2), .perm(perm), .ip_lo(ip_lo), .ip_hi(ip_hi),
    .irq_en(irq_en), .lock(lock), .clr_mask(clr_mask)
  );

  mpu_check #(
    .ADDR_W(ADDR_W), .KW(KW), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI),
    .INFO_LO(INFO_LO), .INFO_HI(INFO_HI)
  ) check_i (
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_pc(acc_pc), .acc_dbg(acc_dbg), .bnd1(bnd1), .bnd2(bnd2),
    .perm(perm), .ip_lo(ip_lo), .ip_hi(ip_hi), .region(region),
    .rights_ok(rights_ok), .ip_block(ip_block), .refused(refused),
    .set_mask(set_mask)
  );

  mpu_flags flags_i (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  assign acc_viol  = refused;
  assign mem_re    = acc_valid && (acc_kind != 2'd1) && !refused;
  assign mem_we    = acc_valid && (acc_kind == 2'd1) && !refused;
  assign acc_rdata = mem_re ? mem_rdata : BLOCKED_WORD;

  // R6: a data read that does not reach memory returns the fixed word
  p_blocked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0 && !mem_re) |-> (acc_rdata == BLOCKED_WORD));

  // R13: unprotected addresses never trip a violation
  p_outside_free_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == RG_NONE) |-> !acc_viol);

  // R10: a violation leaves a pending flag behind
  p_viol_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |=> (flags != '0));

  // R7: no write strobe in a violation cycle
  p_no_we_on_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |-> !(mem_we || mem_re));

endmodule

// File: tb/mpu_top_tb_top.sv
`timescale 1ns/1ps
module mpu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [19:0] acc_addr = '0;
  logic [19:0] acc_pc = '0;
  logic        acc_dbg = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] acc_rdata;
  logic        mem_re, mem_we, acc_viol, irq;

  int total = 0;
  int bad = 0;

  // bench-side model of the configuration
  logic [9:0]  m_b1 = 10'h51, m_b2 = 10'h51, m_lo = 0, m_hi = 0;
  logic [11:0] m_perm = 12'hFFF;
  logic [3:0]  m_en = 0, m_flags = 0;
  logic        m_lock = 0;

  always #4 clk = ~clk;

  mpu_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_pc(acc_pc),
    .acc_dbg(acc_dbg), .mem_rdata(mem_rdata), .acc_rdata(acc_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .acc_viol(acc_viol), .irq(irq)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 none, 1..3 segments, 4 info
  function automatic int exp_region(logic [19:0] a);
    if (a >= 20'h04400 && a < 20'h14400) begin
      if (a < {m_b1, 10'h000}) return 1;
      if (a < {m_b2, 10'h000}) return 2;
      return 3;
    end
    if (a >= 20'h01800 && a < 20'h01A00) return 4;
    return 0;
  endfunction

  function automatic bit in_ip(logic [19:0] a);
    return (a >= {m_lo, 10'h000}) && (a < {m_hi, 10'h000});
  endfunction

  function automatic bit exp_ok(logic [1:0] k, logic [19:0] a, logic [19:0] pc, bit dbg);
    int r = exp_region(a);
    logic [2:0] rw;
    bit granted, ipb;
    if (r == 0) return 1'b1;
    rw = m_perm[3*(r-1) +: 3];
    granted = (k == 2'd0) ? rw[0] : (k == 2'd1) ? rw[1] : rw[2];
    ipb = (r <= 3) && (k == 2'd0) && in_ip(a) && (dbg || !in_ip(pc));
    return granted && !ipb;
  endfunction

  task automatic cfg_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a == 3'd6) m_flags = m_flags & ~d[3:0];
    else if (!m_lock) begin
      case (a)
        3'd0: m_lock = d[0];
        3'd1: m_b1 = d[9:0];
        3'd2: m_b2 = d[9:0];
        3'd3: m_perm = d[11:0];
        3'd4: m_lo = d[9:0];
        3'd5: m_hi = d[9:0];
        3'd7: m_en = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic cfg_rd(logic [2:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic acc(logic [1:0] k, logic [19:0] a, logic [19:0] pc, bit dbg, string req);
    bit ok;
    int r;
    logic [15:0] md;
    @(negedge clk);
    md = 16'($urandom);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_pc = pc; acc_dbg = dbg;
    mem_rdata = md;
    #1;
    ok = exp_ok(k, a, pc, dbg);
    r = exp_region(a);
    check(acc_viol == !ok, {req, " R8 viol"}, acc_viol, !ok);
    check(mem_we == (ok && k == 2'd1), {req, " R7 we"}, mem_we, ok && k == 2'd1);
    check(mem_re == (ok && k != 2'd1), {req, " R6 re"}, mem_re, ok && k != 2'd1);
    if (k != 2'd1)
      check(acc_rdata == (ok ? md : 16'h3FFF), {req, " R6 data"}, acc_rdata,
            ok ? md : 16'h3FFF);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    if (!ok && r != 0) m_flags[r-1] = 1'b1;
  endtask

  function automatic logic [19:0] rand_addr();
    case ($urandom % 5)
      0: return 20'h01800 + 20'($urandom % 20'h200);
      1: return 20'($urandom % 20'h04400);
      2: return {m_b1, 10'h000} + 20'($urandom % 3) - 20'd1;
      default: return 20'h04400 + 20'($urandom % 20'h10000);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents
    cfg_rd(3'd0, 16'h0000, "R1 lock");
    cfg_rd(3'd1, 16'h0051, "R1 bnd1");
    cfg_rd(3'd2, 16'h0051, "R1 bnd2");
    cfg_rd(3'd3, 16'h0FFF, "R1 rights");
    cfg_rd(3'd6, 16'h0000, "R1 flags");
    cfg_rd(3'd7, 16'h0000, "R1 irq enables");
    check(irq == 1'b0, "R1 irq", irq, 0);
    for (int k = 0; k < 4; k++) acc(2'(k), 20'h09000, 20'h05000, 1'b0, "R1 open");

    // R2 / R4 / R5 segments and rights
    cfg_wr(3'd1, 16'h0020);
    cfg_wr(3'd2, 16'h0040);
    cfg_wr(3'd3, 16'b101_100_011_001);
    acc(2'd0, 20'h07FFF, 20'h05000, 1'b0, "R2 seg1 top read");
    acc(2'd1, 20'h07C00, 20'h05000, 1'b0, "R4 seg1 write refused");
    acc(2'd1, 20'h08000, 20'h05000, 1'b0, "R2 seg2 base write");
    acc(2'd1, 20'h083FF, 20'h05000, 1'b0, "R2 low bits ignored");
    acc(2'd0, 20'h10000, 20'h05000, 1'b0, "R4 seg3 read refused");
    acc(2'd2, 20'h10000, 20'h05000, 1'b0, "R4 seg3 fetch");
    acc(2'd3, 20'h04400, 20'h05000, 1'b0, "R4 seg1 fetch refused");
    acc(2'd0, 20'h01800, 20'h05000, 1'b0, "R5 info read");
    acc(2'd1, 20'h019FE, 20'h05000, 1'b0, "R5 info write refused");
    acc(2'd2, 20'h019FE, 20'h05000, 1'b0, "R5 info fetch");
    cfg_rd(3'd6, {12'h0, m_flags}, "R10 flags after refusals");
    check(m_flags == 4'b1101, "R10 model flags", m_flags, 4'b1101);

    // R13 outside protected windows
    cfg_wr(3'd3, 16'h0000);
    acc(2'd1, 20'h00200, 20'h05000, 1'b1, "R13 low");
    acc(2'd0, 20'h14400, 20'h05000, 1'b0, "R13 above main");
    acc(2'd2, 20'h01A00, 20'h05000, 1'b0, "R13 above info");

    // R3 inverted boundaries
    cfg_wr(3'd3, 16'b000_111_000_000);
    cfg_wr(3'd1, 16'h0030);
    cfg_wr(3'd2, 16'h0020);
    acc(2'd0, 20'h08000, 20'h05000, 1'b0, "R3 between refused");
    acc(2'd0, 20'h0C000, 20'h05000, 1'b0, "R3 above b1 in seg3");

    // R9 encapsulated region 0xC000..0xCFFF inside segment 2
    cfg_wr(3'd1, 16'h0020);
    cfg_wr(3'd2, 16'h0040);
    cfg_wr(3'd3, 16'hFFF);
    cfg_wr(3'd4, 16'h0030);
    cfg_wr(3'd5, 16'h0034);
    acc(2'd0, 20'h0C100, 20'h0C200, 1'b0, "R9 inside code read");
    acc(2'd0, 20'h0C100, 20'h05000, 1'b0, "R9 outside code refused");
    acc(2'd0, 20'h0CFFE, 20'h0C200, 1'b1, "R9 debug refused");
    acc(2'd1, 20'h0C100, 20'h05000, 1'b0, "R9 write unaffected");
    acc(2'd2, 20'h0C100, 20'h05000, 1'b1, "R9 fetch unaffected");
    acc(2'd0, 20'h0D000, 20'h05000, 1'b1, "R9 just past region");

    // R11 interrupt enables
    cfg_rd(3'd6, {12'h0, m_flags}, "R10 flags");
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    cfg_wr(3'd7, 16'h0002);
    #1 check(irq == 1'b1, "R11 irq enabled", irq, 1);
    cfg_wr(3'd6, 16'h0002);
    #1 check(irq == 1'b0, "R11 irq after clear", irq, 0);
    cfg_rd(3'd6, {12'h0, m_flags}, "R10 write one clears");

    // R10 set beats a clear in the same cycle
    cfg_wr(3'd6, 16'h000F);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 16'h0002;
    acc_valid = 1'b1; acc_kind = 2'd0; acc_addr = 20'h0C100; acc_pc = 20'h05000; acc_dbg = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    m_flags = 4'b0010;
    cfg_rd(3'd6, 16'h0002, "R10 set wins");
    cfg_wr(3'd6, 16'h000F);

    // random maps
    for (int round = 0; round < 20; round++) begin
      cfg_wr(3'd1, 16'(10'h11 + ($urandom % 10'h41)));
      cfg_wr(3'd2, 16'(10'h11 + ($urandom % 10'h41)));
      cfg_wr(3'd3, 16'($urandom % 13'h1000));
      cfg_wr(3'd4, 16'(10'h11 + ($urandom % 10'h30)));
      cfg_wr(3'd5, 16'(m_lo + 10'($urandom % 10'h10)));
      cfg_wr(3'd7, 16'($urandom % 16));
      for (int n = 0; n < 100; n++) begin
        logic [19:0] a, pc;
        a = rand_addr();
        pc = ($urandom % 2) ? {m_lo, 10'h000} + 20'($urandom % 20'h400)
                            : 20'h04400 + 20'($urandom % 20'h10000);
        acc(2'($urandom), a, pc, 1'($urandom % 4 == 0), "R4 R9 random");
      end
      cfg_rd(3'd6, {12'h0, m_flags}, "R10 random flags");
      #1 check(irq == |(m_flags & m_en), "R11 random irq", irq, |(m_flags & m_en));
      cfg_wr(3'd6, 16'h000F);
    end

    // R12 lock
    cfg_wr(3'd1, 16'h0022);
    cfg_wr(3'd3, 16'h0000);
    cfg_wr(3'd7, 16'h000F);
    cfg_wr(3'd0, 16'h0001);
    cfg_wr(3'd1, 16'h0033);
    cfg_wr(3'd3, 16'h0FFF);
    cfg_wr(3'd7, 16'h0000);
    cfg_wr(3'd0, 16'h0000);
    cfg_rd(3'd0, 16'h0001, "R12 lock stays");
    cfg_rd(3'd1, 16'h0022, "R12 bnd1 frozen");
    cfg_rd(3'd3, 16'h0000, "R12 rights frozen");
    cfg_rd(3'd7, 16'h000F, "R12 enables frozen");
    acc(2'd1, 20'h09000, 20'h05000, 1'b0, "R12 rights still enforced");
    cfg_wr(3'd6, 16'h000F);
    cfg_rd(3'd6, 16'h0000, "R12 flag clear while locked");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule